// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block decides which side of a two-sided memory may touch a location when both sides select the same word at once. Each side presents an enable and an address. A collision exists only when both enables are active and the two addresses are equal. When that happens, one side keeps access and the other side sees its active-low busy flag asserted, together with a write-inhibit flag that blocks its memory write.

The side whose access began in an earlier cycle wins. If both accesses begin in the same cycle, the left side wins. A winning side keeps its access until it drops its enable or moves to another address. Everything runs on one synchronous clock, and every output is a register.

For width expansion, several copies can be cascaded. A copy in master mode makes its own decisions and drives the outcome on its busy outputs. A copy in slave mode makes no decisions. It copies the busy levels it receives from the master. It also holds off a write during the first cycle of any new access, while the received busy level is not yet stable.

Top module: `dpa_contention_arb`

## Requirements
- R1: While `rst` is high, and on the first edge that samples it high, both busy outputs go high (inactive) and both write-inhibit outputs go low. The arbitration history is cleared.
- R2: In master mode, if an edge samples no collision (an enable low, or the addresses differ), both busy outputs are high after that edge.
- R3: In master mode, on a collision where one side's access is older, the newer side loses: its busy goes low after that edge. A side's access is new when it was disabled, or at another address, at the previous edge.
- R4: In master mode, if both accesses are new on the collision edge, the left side wins and `busy_right_n` goes low.
- R5: While the winner keeps its enable and address and the collision persists, the same side keeps winning and the loser's busy stays low.
- R6: When the winner drops its enable, the loser's busy returns high after the next edge.
- R7: In master mode the two busy outputs are never low together.
- R8: In slave mode, each busy output equals the matching external busy input sampled at the previous edge. The enables and addresses have no effect on busy.
- R9: In master mode, each write-inhibit output is the inverse of that side's busy output.
- R10: In slave mode, a side's write-inhibit is high after an edge where its external busy is low, or where that side's access is new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = decide locally, 0 = follow external busy |
| left_en | input | 1 | Left side enable, active high |
| left_addr | input | ADDR_W | Left side word address |
| right_en | input | 1 | Right side enable, active high |
| right_addr | input | ADDR_W | Right side word address |
| ext_busy_left_n | input | 1 | Busy for the left side from a master, active low (slave mode) |
| ext_busy_right_n | input | 1 | Busy for the right side from a master, active low (slave mode) |
| busy_left_n | output | 1 | Left side busy, active low |
| busy_right_n | output | 1 | Right side busy, active low |
| winh_left | output | 1 | Left side write inhibit, active high |
| winh_right | output | 1 | Right side write inhibit, active high |

## Verification
Every result is due exactly one edge after the stimulus that causes it. The decision and both output flags are all registered from the inputs sampled at that edge. The "new access" history comes from the edge before, so a collision's winner depends on two consecutive edges.

The bench drives inputs on the falling edge, lets one rising edge pass and compares all four outputs on the following falling edge. The vector sequence is therefore ordered so that each entry's history is set up by the entry before it.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  // an access is new when it starts from idle or jumps to another word
  assign fresh = en && (!prev_en || (addr != prev_addr));

  // R3: an enable rising from idle always counts as a new access
  a_r3_fresh_from_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && en) |-> fresh);
endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master_mode,
  input  logic   match,
  input  logic   fresh_l,
  input  logic   fresh_r,
  output owner_e owner_nxt
);
  owner_e owner_q;

  always_comb begin
    if (!master_mode || !match)           owner_nxt = OWN_NONE;
    else if (owner_q == OWN_LEFT  && !fresh_l) owner_nxt = OWN_LEFT;
    else if (owner_q == OWN_RIGHT && !fresh_r) owner_nxt = OWN_RIGHT;
    else if (fresh_l && !fresh_r)         owner_nxt = OWN_RIGHT;
    else                                  owner_nxt = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_nxt;
  end

  // R5: a held winner keeps ownership while the collision lasts
  a_r5_hold_left: assert property (@(posedge clk) disable iff (rst)
    (master_mode && match && owner_q == OWN_LEFT && !fresh_l) |=> owner_q == OWN_LEFT);
  a_r5_hold_right: assert property (@(posedge clk) disable iff (rst)
    (master_mode && match && owner_q == OWN_RIGHT && !fresh_r) |=> owner_q == OWN_RIGHT);
  // R4: two new accesses on a collision go to the left side
  a_r4_tie_left: assert property (@(posedge clk) disable iff (rst)
    (master_mode && match && fresh_l && fresh_r) |=> owner_q == OWN_LEFT);
endmodule

// File: rtl/dpa_out_stage.sv
module dpa_out_stage
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master_mode,
  input  owner_e owner_nxt,
  input  logic   ext_l_n,
  input  logic   ext_r_n,
  input  logic   fresh_l,
  input  logic   fresh_r,
  output logic   busy_l_n,
  output logic   busy_r_n,
  output logic   winh_l,
  output logic   winh_r
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_l_n <= 1'b1;
      busy_r_n <= 1'b1;
      winh_l   <= 1'b0;
      winh_r   <= 1'b0;
    end else if (master_mode) begin
      busy_l_n <= (owner_nxt != OWN_RIGHT);
      busy_r_n <= (owner_nxt != OWN_LEFT);
      winh_l   <= (owner_nxt == OWN_RIGHT);
      winh_r   <= (owner_nxt == OWN_LEFT);
    end else begin
      busy_l_n <= ext_l_n;
      busy_r_n <= ext_r_n;
      winh_l   <= !ext_l_n || fresh_l;
      winh_r   <= !ext_r_n || fresh_r;
    end
  end

  // R10: a new slave access is write-inhibited for its first cycle
  a_r10_slave_settle_l: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(master_mode) && $past(fresh_l)) |-> winh_l);
  a_r10_slave_settle_r: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(master_mode) && $past(fresh_r)) |-> winh_r);
endmodule

// File: rtl/dpa_contention_arb.sv
module dpa_contention_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              left_en,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              right_en,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              ext_busy_left_n,
  input  logic              ext_busy_right_n,
  output logic              busy_left_n,
  output logic              busy_right_n,
  output logic              winh_left,
  output logic              winh_right
);
  localparam int NSIDE = 2;

  logic              side_en   [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];
  logic              side_new  [NSIDE];
  logic              match;
  owner_e            owner_nxt;
  logic              live_q;

  assign side_en[0]   = left_en;
  assign side_en[1]   = right_en;
  assign side_addr[0] = left_addr;
  assign side_addr[1] = right_addr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk  (clk),
      .rst  (rst),
      .en   (side_en[s]),
      .addr (side_addr[s]),
      .fresh(side_new[s])
    );
  end

  assign match = left_en && right_en && (left_addr == right_addr);

  dpa_decide u_decide (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .match      (match),
    .fresh_l    (side_new[0]),
    .fresh_r    (side_new[1]),
    .owner_nxt  (owner_nxt)
  );

  dpa_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .owner_nxt  (owner_nxt),
    .ext_l_n    (ext_busy_left_n),
    .ext_r_n    (ext_busy_right_n),
    .fresh_l    (side_new[0]),
    .fresh_r    (side_new[1]),
    .busy_l_n   (busy_left_n),
    .busy_r_n   (busy_right_n),
    .winh_l     (winh_left),
    .winh_r     (winh_right)
  );

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R1: reset leaves both sides free
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (busy_left_n && busy_right_n && !winh_left && !winh_right));
  // R2: no collision means no busy in master mode
  a_r2_free_without_match: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(master_mode) &&
     !$past(left_en && right_en && left_addr == right_addr))
    |-> (busy_left_n && busy_right_n));
  // R7: one loser at most
  a_r7_single_loser: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(master_mode)) |-> (busy_left_n || busy_right_n));
  // R9: write inhibit tracks busy in master mode
  a_r9_winh_is_busy: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(master_mode))
    |-> (winh_left == !busy_left_n && winh_right == !busy_right_n));
  // R8: slave busy copies the external levels one edge later
  a_r8_slave_copy: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(master_mode))
    |-> (busy_left_n == $past(ext_busy_left_n) && busy_right_n == $past(ext_busy_right_n)));
endmodule

// File: tb/sim_dpa_contention_arb.sv
module sim_dpa_contention_arb;
  localparam int AW = 16;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic          master_mode;
  logic          left_en, right_en;
  logic [AW-1:0] left_addr, right_addr;
  logic          ext_busy_left_n, ext_busy_right_n;
  logic          busy_left_n, busy_right_n, winh_left, winh_right;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  dpa_contention_arb #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .left_en(left_en), .left_addr(left_addr),
    .right_en(right_en), .right_addr(right_addr),
    .ext_busy_left_n(ext_busy_left_n), .ext_busy_right_n(ext_busy_right_n),
    .busy_left_n(busy_left_n), .busy_right_n(busy_right_n),
    .winh_left(winh_left), .winh_right(winh_right)
  );

  // {master, len, laddr, ren, raddr, ext_l_n, ext_r_n, exp{bl_n,br_n,wl,wr}, req}
  localparam logic [32:0] TBL [NV] = '{
    {1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  2'b11, 4'b1100, 8'd2},   // R2 idle
    {1'b1, 1'b1, 8'd5,  1'b1, 8'd6,  2'b11, 4'b1100, 8'd2},   // R2 different words
    {1'b1, 1'b1, 8'd5,  1'b1, 8'd5,  2'b11, 4'b1001, 8'd3},   // R3 right newer loses, R9
    {1'b1, 1'b1, 8'd5,  1'b1, 8'd5,  2'b11, 4'b1001, 8'd5},   // R5 held
    {1'b1, 1'b0, 8'd5,  1'b1, 8'd5,  2'b11, 4'b1100, 8'd6},   // R6 winner leaves
    {1'b1, 1'b1, 8'd5,  1'b1, 8'd5,  2'b11, 4'b0110, 8'd3},   // R3 left newer loses
    {1'b1, 1'b0, 8'd5,  1'b0, 8'd5,  2'b11, 4'b1100, 8'd2},   // R2
    {1'b1, 1'b1, 8'd9,  1'b1, 8'd9,  2'b11, 4'b1001, 8'd4},   // R4 tie to left
    {1'b1, 1'b1, 8'd9,  1'b1, 8'd9,  2'b11, 4'b1001, 8'd5},   // R5
    {1'b1, 1'b1, 8'd9,  1'b1, 8'd10, 2'b11, 4'b1100, 8'd2},   // R2 right moves away
    {1'b1, 1'b1, 8'd3,  1'b1, 8'd3,  2'b11, 4'b1001, 8'd4},   // R4
    {1'b1, 1'b1, 8'd4,  1'b1, 8'd4,  2'b11, 4'b1001, 8'd4},   // R4 both jump together
    {1'b0, 1'b1, 8'd7,  1'b1, 8'd7,  2'b11, 4'b1111, 8'd10},  // R10 new slave access, R8
    {1'b0, 1'b1, 8'd7,  1'b1, 8'd7,  2'b11, 4'b1100, 8'd8},   // R8 no own decision
    {1'b0, 1'b1, 8'd7,  1'b1, 8'd7,  2'b01, 4'b0110, 8'd8},   // R8 left busy copied
    {1'b0, 1'b1, 8'd7,  1'b1, 8'd7,  2'b10, 4'b1001, 8'd8},   // R8 right busy copied
    {1'b0, 1'b0, 8'd7,  1'b0, 8'd7,  2'b00, 4'b0011, 8'd8},   // R8 ignores enables
    {1'b1, 1'b0, 8'd0,  1'b0, 8'd0,  2'b11, 4'b1100, 8'd2}    // R2 back to master
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {busy_left_n, busy_right_n, winh_left, winh_right};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; master_mode = 1'b1;
    left_en = 1'b0; right_en = 1'b0; left_addr = '0; right_addr = '0;
    ext_busy_left_n = 1'b1; ext_busy_right_n = 1'b1;
    @(negedge clk);
    step();
    check(4'b1100, "R1 reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      master_mode      = TBL[i][32];
      left_en          = TBL[i][31];
      left_addr        = AW'(TBL[i][30:23]);
      right_en         = TBL[i][22];
      right_addr       = AW'(TBL[i][21:14]);
      ext_busy_left_n  = TBL[i][13];
      ext_busy_right_n = TBL[i][12];
      step();
      check(TBL[i][11:8], $sformatf("R%0d vector %0d", TBL[i][7:0], i));
      if (master_mode) begin
        n_checks++;
        if (!busy_left_n && !busy_right_n) begin
          n_fail++;
          $display("FAIL R7 vector %0d: got both busy expected one at most", i);
        end
      end
    end

    // R1: reset in the middle of a collision
    master_mode = 1'b1; left_en = 1'b1; right_en = 1'b1;
    left_addr = 16'h00A2; right_addr = 16'h00A2;
    step();
    check(4'b1001, "R4 collision before reset");
    rst = 1'b1;
    step();
    check(4'b1100, "R1 reset during collision");
    rst = 1'b0;
    step();
    check(4'b1001, "R4 history cleared by reset");

    // R3 with wide addresses: right older, left arrives later
    left_en = 1'b0; right_addr = 16'hFFFF;
    step();
    check(4'b1100, "R6 left released");
    left_en = 1'b1; left_addr = 16'hFFFF;
    step();
    check(4'b0110, "R3 top address, left newer");
    left_addr = 16'hFFFE;
    step();
    check(4'b1100, "R2 addresses differ in bit 0");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule